// File: doc/BRIEF.md
# Debug Port Control and Status Register

This block holds the 32-bit control and status word of a debug port. A host writes and reads it through a simple register interface, decoded at one offset. It drives the system power-up, debug power-up and debug reset request outputs. It samples the three matching acknowledge inputs through a synchroniser and reports them as read-only status. It also gathers events from the access-port side into sticky status flags: transaction errors, read responses, overruns, write-data faults and discarded writes.

A parameter selects the link flavour. The scan-chain flavour lets the host clear the sticky error and overrun flags by writing ones to them, and it hides the read-response and write-data-error flags. The two-wire flavour makes every flag read-only to the host and exposes all of them. On both flavours, per-flag clear strobes from a separate abort register write can clear the flags. An error-mode bit stops transaction errors from being recorded, and an enable bit gates overrun capture.

Top module: `dbg_ctrlstat_reg`

## Requirements
- R1: After reset, a read at the register offset returns 0 (with acknowledge inputs low) and all three request outputs are 0.
- R2: Bits 30, 28 and 26 are host read-write and drive sys_pwr_req, dbg_pwr_req and dbg_rst_req respectively from the cycle after the write.
- R3: Bits 31, 29 and 27 report sys_pwr_ack, dbg_pwr_ack and dbg_rst_ack after two clock edges of synchronisation, and host writes never change them.
- R4: Bit 24 is host read-write. While it is 0, an ap_err pulse sets the sticky error flag at bit 5. While it is 1, ap_err leaves bit 5 unchanged.
- R5: Bit 0 is host read-write. An ap_orun pulse sets the sticky overrun flag at bit 1 only while bit 0 is 1.
- R6: On the scan-chain flavour, a host write with bit 5 or bit 1 at 1 clears that flag, and a 0 there leaves the flag alone. On the two-wire flavour, host writes never change bits 5 and 1.
- R7: On both flavours, abt_stk_clr clears bit 5 and abt_orun_clr clears bit 1.
- R8: On the two-wire flavour, bit 6 takes the value of ap_rd_ok in each cycle that ap_rd_done is 1 and holds otherwise. On the scan-chain flavour it reads 0.
- R9: On the two-wire flavour, bit 7 is set by wr_data_err or wr_discard and cleared only by abt_wderr_clr. Host writes do not touch it. On the scan-chain flavour it reads 0.
- R10: When a set event and a clear for the same flag arrive in one cycle, the flag ends up 1.
- R11: Bits 25, 23 to 8 and 4 to 2 read 0 and ignore writes. A write at any other address changes nothing, and a read at any other address returns 0.
- R12: rd_data shows the current state in the same cycle rd_en is high, is 0 while rd_en is low, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Host register address |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 32 | Host read data, combinational |
| sys_pwr_req | output | 1 | System power-up request |
| dbg_pwr_req | output | 1 | Debug power-up request |
| dbg_rst_req | output | 1 | Debug reset request |
| sys_pwr_ack | input | 1 | System power-up acknowledge, asynchronous |
| dbg_pwr_ack | input | 1 | Debug power-up acknowledge, asynchronous |
| dbg_rst_ack | input | 1 | Debug reset acknowledge, asynchronous |
| ap_err | input | 1 | Access-port transaction error event |
| ap_orun | input | 1 | Overrun event |
| ap_rd_done | input | 1 | Access-port or read-buffer read completed |
| ap_rd_ok | input | 1 | Response of that read was OK |
| wr_data_err | input | 1 | Parity or framing error in a write data phase |
| wr_discard | input | 1 | Accepted write dropped before the access port |
| abt_stk_clr | input | 1 | Abort clear strobe for the sticky error flag |
| abt_orun_clr | input | 1 | Abort clear strobe for the sticky overrun flag |
| abt_wderr_clr | input | 1 | Abort clear strobe for the write-data-error flag |

## Verification
The bench drives a set event and a clear into the same cycle. A design that gives the clear priority would read the flag back as 0 and lose the event. It writes ones across the whole word on the two-wire flavour and writes ones and zeros to the flag bits on the scan-chain flavour. A design that mixes up the flavour rules would either clear flags it must keep or keep flags it must clear. It also pulses ap_err with the error mode set and ap_orun with detection off, and checks that the acknowledge bits appear exactly two edges after their inputs change. Writes and reads at a foreign address are checked as well, because a design that decoded the address loosely would move the request outputs.

// File: rtl/dbg_cs_pkg.sv
package dbg_cs_pkg;

    typedef enum logic {
        LINK_TWOWIRE = 1'b0,
        LINK_SCAN    = 1'b1
    } link_e;

    localparam int WORD_W    = 32;
    localparam int NUM_ACK   = 3;

    localparam int B_SYS_ACK = 31;
    localparam int B_SYS_REQ = 30;
    localparam int B_DBG_ACK = 29;
    localparam int B_DBG_REQ = 28;
    localparam int B_RST_ACK = 27;
    localparam int B_RST_REQ = 26;
    localparam int B_ERRMODE = 24;
    localparam int B_WDERR   = 7;
    localparam int B_RDOK    = 6;
    localparam int B_STKERR  = 5;
    localparam int B_STKORUN = 1;
    localparam int B_ORUNEN  = 0;

    localparam logic [WORD_W-1:0] USED_MASK =
        (WORD_W'(1) << B_SYS_ACK) | (WORD_W'(1) << B_SYS_REQ) |
        (WORD_W'(1) << B_DBG_ACK) | (WORD_W'(1) << B_DBG_REQ) |
        (WORD_W'(1) << B_RST_ACK) | (WORD_W'(1) << B_RST_REQ) |
        (WORD_W'(1) << B_ERRMODE) | (WORD_W'(1) << B_WDERR)   |
        (WORD_W'(1) << B_RDOK)    | (WORD_W'(1) << B_STKERR)  |
        (WORD_W'(1) << B_STKORUN) | (WORD_W'(1) << B_ORUNEN);
    localparam logic [WORD_W-1:0] RSVD_MASK = ~USED_MASK;

    // Host-writable control fields
    typedef struct packed {
        logic sys_req;
        logic dbg_req;
        logic rst_req;
        logic errmode;
        logic orun_en;
    } ctl_t;

    // Sticky and tracked status flags
    typedef struct packed {
        logic wderr;
        logic rdok;
        logic stkerr;
        logic stkorun;
    } flags_t;

    function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.sys_req = w[B_SYS_REQ];
        c.dbg_req = w[B_DBG_REQ];
        c.rst_req = w[B_RST_REQ];
        c.errmode = w[B_ERRMODE];
        c.orun_en = w[B_ORUNEN];
        return c;
    endfunction

    // ack order: [2] system power, [1] debug power, [0] debug reset
    function automatic logic [WORD_W-1:0] pack_word(input ctl_t c,
                                                    input logic [NUM_ACK-1:0] ack,
                                                    input flags_t f);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[B_SYS_ACK] = ack[2];
        w[B_SYS_REQ] = c.sys_req;
        w[B_DBG_ACK] = ack[1];
        w[B_DBG_REQ] = c.dbg_req;
        w[B_RST_ACK] = ack[0];
        w[B_RST_REQ] = c.rst_req;
        w[B_ERRMODE] = c.errmode;
        w[B_WDERR]   = f.wderr;
        w[B_RDOK]    = f.rdok;
        w[B_STKERR]  = f.stkerr;
        w[B_STKORUN] = f.stkorun;
        w[B_ORUNEN]  = c.orun_en;
        return w;
    endfunction

endpackage

// File: rtl/cs_ack_sync.sv
module cs_ack_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cs_sticky_flag.sv
module cs_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag_q
);

    // A set in the same cycle as a clear keeps the flag high
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
        end else if (clr_ev) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_ctrlstat_reg.sv
module dbg_ctrlstat_reg
    import dbg_cs_pkg::*;
#(
    parameter link_e             LINK        = LINK_TWOWIRE,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET  = ADDR_W'(4),
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              sys_pwr_req,
    output logic              dbg_pwr_req,
    output logic              dbg_rst_req,
    input  logic              sys_pwr_ack,
    input  logic              dbg_pwr_ack,
    input  logic              dbg_rst_ack,
    input  logic              ap_err,
    input  logic              ap_orun,
    input  logic              ap_rd_done,
    input  logic              ap_rd_ok,
    input  logic              wr_data_err,
    input  logic              wr_discard,
    input  logic              abt_stk_clr,
    input  logic              abt_orun_clr,
    input  logic              abt_wderr_clr
);

    localparam bit IS_SCAN = (LINK == LINK_SCAN);

    logic               wr_hit;
    logic               rd_hit;
    logic               w1c_en;
    ctl_t               ctl_q;
    logic [NUM_ACK-1:0] ack_s;
    logic               stkerr_q;
    logic               stkorun_q;
    logic               wderr_q;
    logic               rdok_q;
    flags_t             flags_vis;

    assign wr_hit = wr_en && (addr == REG_OFFSET);
    assign rd_hit = rd_en && (addr == REG_OFFSET);
    assign w1c_en = IS_SCAN && wr_hit;

    // Host control fields
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_hit) begin
            ctl_q <= decode_ctl(wr_data);
        end
    end

    assign sys_pwr_req = ctl_q.sys_req;
    assign dbg_pwr_req = ctl_q.dbg_req;
    assign dbg_rst_req = ctl_q.rst_req;

    cs_ack_sync #(
        .WIDTH  (NUM_ACK),
        .STAGES (SYNC_STAGES)
    ) u_ack_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({sys_pwr_ack, dbg_pwr_ack, dbg_rst_ack}),
        .sync_out (ack_s)
    );

    cs_sticky_flag u_stkerr (
        .clk    (clk),
        .rst    (rst),
        .set_ev (ap_err && !ctl_q.errmode),
        .clr_ev (abt_stk_clr || (w1c_en && wr_data[B_STKERR])),
        .flag_q (stkerr_q)
    );

    cs_sticky_flag u_stkorun (
        .clk    (clk),
        .rst    (rst),
        .set_ev (ap_orun && ctl_q.orun_en),
        .clr_ev (abt_orun_clr || (w1c_en && wr_data[B_STKORUN])),
        .flag_q (stkorun_q)
    );

    cs_sticky_flag u_wderr (
        .clk    (clk),
        .rst    (rst),
        .set_ev (wr_data_err || wr_discard),
        .clr_ev (abt_wderr_clr),
        .flag_q (wderr_q)
    );

    // Response of the latest completed read
    always_ff @(posedge clk) begin
        if (rst) begin
            rdok_q <= 1'b0;
        end else if (ap_rd_done) begin
            rdok_q <= ap_rd_ok;
        end
    end

    // Flags that exist only on the two-wire flavour read as zero on scan
    always_comb begin
        flags_vis.stkerr  = stkerr_q;
        flags_vis.stkorun = stkorun_q;
        flags_vis.wderr   = IS_SCAN ? 1'b0 : wderr_q;
        flags_vis.rdok    = IS_SCAN ? 1'b0 : rdok_q;
    end

    assign rd_data = rd_hit ? pack_word(ctl_q, ack_s, flags_vis) : '0;

endmodule

// File: rtl/dbg_ctrlstat_chk.sv
module dbg_ctrlstat_chk
    import dbg_cs_pkg::*;
#(
    parameter link_e             LINK       = LINK_TWOWIRE,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(4)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [2:0]        wr_req_bits,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              sys_pwr_req,
    input logic              dbg_pwr_req,
    input logic              dbg_rst_req,
    input logic              ap_err,
    input logic              ap_orun,
    input logic              abt_stk_clr,
    input logic              errmode,
    input logic              orun_en,
    input logic              stkerr,
    input logic              stkorun
);

    logic       wr_at;
    logic       rd_at;
    logic [2:0] reqs;

    assign wr_at = wr_en && (addr == REG_OFFSET);
    assign rd_at = rd_en && (addr == REG_OFFSET);
    assign reqs  = {sys_pwr_req, dbg_pwr_req, dbg_rst_req};

    AST_REQ_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_at |=> reqs == $past(wr_req_bits)); // R2
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_at |=> $stable(reqs)); // R2
    AST_ERR_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        (ap_err && !errmode) |=> stkerr); // R4
    AST_ERR_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ap_err && errmode && !stkerr) |=> !stkerr); // R4
    AST_ORUN_GATED: assert property (@(posedge clk) disable iff (rst)
        (!orun_en && !stkorun) |=> !stkorun); // R5
    AST_ABORT_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
        (abt_stk_clr && !(ap_err && !errmode)) |=> !stkerr); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_at |-> (rd_data & RSVD_MASK) == '0); // R11
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_at |-> rd_data == '0); // R12

    if (LINK == LINK_SCAN) begin : g_scan
        AST_SCAN_HIDES_FLAGS: assert property (@(posedge clk) disable iff (rst)
            rd_at |-> rd_data[B_WDERR:B_RDOK] == 2'b00); // R8
    end else begin : g_twowire
        AST_HOST_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (stkerr && !abt_stk_clr) |=> stkerr); // R6
    end

endmodule

bind dbg_ctrlstat_reg dbg_ctrlstat_chk #(
    .LINK       (LINK),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_req_bits ({wr_data[30], wr_data[28], wr_data[26]}),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .sys_pwr_req (sys_pwr_req),
    .dbg_pwr_req (dbg_pwr_req),
    .dbg_rst_req (dbg_rst_req),
    .ap_err      (ap_err),
    .ap_orun     (ap_orun),
    .abt_stk_clr (abt_stk_clr),
    .errmode     (ctl_q.errmode),
    .orun_en     (ctl_q.orun_en),
    .stkerr      (stkerr_q),
    .stkorun     (stkorun_q)
);

// File: tb/test_dbg_ctrlstat_reg.sv
`timescale 1ns/1ps
module test_dbg_ctrlstat_reg;
    import dbg_cs_pkg::*;

    localparam logic [7:0] OFS   = 8'h04;
    localparam logic [7:0] OTHER = 8'h08;

    // event bit encoding of the stimulus table
    localparam logic [8:0] EV_ERR   = 9'h001;
    localparam logic [8:0] EV_ORUN  = 9'h002;
    localparam logic [8:0] EV_WDE   = 9'h004;
    localparam logic [8:0] EV_DISC  = 9'h008;
    localparam logic [8:0] EV_RDD   = 9'h010;
    localparam logic [8:0] EV_RDOK  = 9'h020;
    localparam logic [8:0] EV_CSTK  = 9'h040;
    localparam logic [8:0] EV_CORUN = 9'h080;
    localparam logic [8:0] EV_CWD   = 9'h100;

    typedef struct packed {
        logic        wr;
        logic [31:0] wd;
        logic [8:0]  ev;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Two-wire flavour, walked from reset with acknowledges low
    localparam vec_t TABLE [21] = '{
        '{1'b1, 32'h5400_0000, 9'h0,             32'h5400_0000, 8'd2},  // R2
        '{1'b1, 32'h0000_0001, 9'h0,             32'h0000_0001, 8'd2},  // R2
        '{1'b0, 32'h0,         EV_ORUN,          32'h0000_0003, 8'd5},  // R5
        '{1'b1, 32'hFFFF_FFFF, 9'h0,             32'h5500_0003, 8'd6},  // R6 R11
        '{1'b0, 32'h0,         EV_ERR,           32'h5500_0003, 8'd4},  // R4
        '{1'b1, 32'h0000_0001, 9'h0,             32'h0000_0003, 8'd4},  // R4
        '{1'b0, 32'h0,         EV_ERR,           32'h0000_0023, 8'd4},  // R4
        '{1'b0, 32'h0,         EV_CORUN,         32'h0000_0021, 8'd7},  // R7
        '{1'b1, 32'h0,         9'h0,             32'h0000_0020, 8'd5},  // R5
        '{1'b0, 32'h0,         EV_ORUN,          32'h0000_0020, 8'd5},  // R5
        '{1'b0, 32'h0,         EV_ERR | EV_CSTK, 32'h0000_0020, 8'd10}, // R10
        '{1'b0, 32'h0,         EV_CSTK,          32'h0000_0000, 8'd7},  // R7
        '{1'b0, 32'h0,         EV_RDD | EV_RDOK, 32'h0000_0040, 8'd8},  // R8
        '{1'b0, 32'h0,         EV_RDOK,          32'h0000_0040, 8'd8},  // R8
        '{1'b0, 32'h0,         EV_RDD,           32'h0000_0000, 8'd8},  // R8
        '{1'b0, 32'h0,         EV_WDE,           32'h0000_0080, 8'd9},  // R9
        '{1'b1, 32'h0000_00E2, 9'h0,             32'h0000_0080, 8'd9},  // R9
        '{1'b0, 32'h0,         EV_CWD,           32'h0000_0000, 8'd9},  // R9
        '{1'b0, 32'h0,         EV_DISC,          32'h0000_0080, 8'd9},  // R9
        '{1'b0, 32'h0,         EV_CWD | EV_WDE,  32'h0000_0080, 8'd10}, // R10
        '{1'b0, 32'h0,         EV_CWD,           32'h0000_0000, 8'd9}   // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = OFS;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        sys_pwr_ack = 1'b0, dbg_pwr_ack = 1'b0, dbg_rst_ack = 1'b0;
    logic        ap_err = 1'b0, ap_orun = 1'b0, ap_rd_done = 1'b0, ap_rd_ok = 1'b0;
    logic        wr_data_err = 1'b0, wr_discard = 1'b0;
    logic        abt_stk_clr = 1'b0, abt_orun_clr = 1'b0, abt_wderr_clr = 1'b0;

    logic [31:0] rd_tw, rd_sc;
    logic        req_tw_sys, req_tw_dbg, req_tw_rst;
    logic        req_sc_sys, req_sc_dbg, req_sc_rst;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    dbg_ctrlstat_reg #(.LINK(LINK_TWOWIRE)) i_dbg_ctrlstat_reg (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_tw),
        .sys_pwr_req(req_tw_sys), .dbg_pwr_req(req_tw_dbg), .dbg_rst_req(req_tw_rst),
        .sys_pwr_ack(sys_pwr_ack), .dbg_pwr_ack(dbg_pwr_ack), .dbg_rst_ack(dbg_rst_ack),
        .ap_err(ap_err), .ap_orun(ap_orun), .ap_rd_done(ap_rd_done), .ap_rd_ok(ap_rd_ok),
        .wr_data_err(wr_data_err), .wr_discard(wr_discard),
        .abt_stk_clr(abt_stk_clr), .abt_orun_clr(abt_orun_clr), .abt_wderr_clr(abt_wderr_clr)
    );

    dbg_ctrlstat_reg #(.LINK(LINK_SCAN)) i_dbg_ctrlstat_reg_scan (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_sc),
        .sys_pwr_req(req_sc_sys), .dbg_pwr_req(req_sc_dbg), .dbg_rst_req(req_sc_rst),
        .sys_pwr_ack(sys_pwr_ack), .dbg_pwr_ack(dbg_pwr_ack), .dbg_rst_ack(dbg_rst_ack),
        .ap_err(ap_err), .ap_orun(ap_orun), .ap_rd_done(ap_rd_done), .ap_rd_ok(ap_rd_ok),
        .wr_data_err(wr_data_err), .wr_discard(wr_discard),
        .abt_stk_clr(abt_stk_clr), .abt_orun_clr(abt_orun_clr), .abt_wderr_clr(abt_wderr_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive for one rising edge, then release
    task automatic drive(input logic w, input logic [31:0] wd, input logic [8:0] ev);
        wr_en   = w;
        wr_data = wd;
        {abt_wderr_clr, abt_orun_clr, abt_stk_clr, ap_rd_ok, ap_rd_done,
         wr_discard, wr_data_err, ap_orun, ap_err} = ev;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        {abt_wderr_clr, abt_orun_clr, abt_stk_clr, ap_rd_ok, ap_rd_done,
         wr_discard, wr_data_err, ap_orun, ap_err} = '0;
    endtask

    task automatic sample;
        rd_en = 1'b1;
        #1;
        rd_en = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    always @(rd_en) if (rd_en) #0.5 begin end

    initial begin
        logic [31:0] tw, sc;
        do_reset();

        // R1: reset state of both flavours
        rd_en = 1'b1; #1; tw = rd_tw; sc = rd_sc; rd_en = 1'b0;
        chk("R1 two-wire word", tw, 32'h0);
        chk("R1 scan word", sc, 32'h0);
        chk("R1 requests", {29'h0, req_tw_sys, req_tw_dbg, req_tw_rst}, 32'h0);

        // Table walk on the two-wire flavour
        for (int i = 0; i < 21; i++) begin
            drive(TABLE[i].wr, TABLE[i].wd, TABLE[i].ev);
            rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
            checks++;
            if (tw !== TABLE[i].exp) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual %h expected %h",
                         TABLE[i].req, i, tw, TABLE[i].exp);
            end
        end

        // R2: request outputs follow their bits
        drive(1'b1, 32'h5400_0000, 9'h0);
        chk("R2 all requests", {29'h0, req_tw_sys, req_tw_dbg, req_tw_rst}, 32'h7);
        drive(1'b1, 32'h1000_0000, 9'h0);
        chk("R2 debug power only", {29'h0, req_tw_sys, req_tw_dbg, req_tw_rst}, 32'h2);

        // R1: reset in mid-run returns everything to zero
        drive(1'b1, 32'h5500_0001, EV_WDE);
        do_reset();
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R1 word after reset", tw, 32'h0);
        chk("R1 requests after reset", {29'h0, req_tw_sys, req_tw_dbg, req_tw_rst}, 32'h0);

        // R3: two-edge synchroniser on the acknowledges
        sys_pwr_ack = 1'b1;
        @(negedge clk);
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R3 ack after one edge", tw, 32'h0);
        @(negedge clk);
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R3 ack after two edges", tw, 32'h8000_0000);
        dbg_pwr_ack = 1'b1;
        dbg_rst_ack = 1'b1;
        repeat (2) @(negedge clk);
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R3 all acks", tw, 32'hA800_0000);
        drive(1'b1, 32'h0, 9'h0);
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R3 write leaves acks", tw, 32'hA800_0000);
        sys_pwr_ack = 1'b0; dbg_pwr_ack = 1'b0; dbg_rst_ack = 1'b0;
        repeat (2) @(negedge clk);
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R3 acks dropped", tw, 32'h0);

        // R11: foreign address
        addr = OTHER;
        drive(1'b1, 32'h5400_0000, 9'h0);
        chk("R11 foreign write no request", {29'h0, req_tw_sys, req_tw_dbg, req_tw_rst}, 32'h0);
        drive(1'b0, 32'h0, EV_ERR);
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R11 foreign read zero", tw, 32'h0);
        addr = OFS;
        rd_en = 1'b1; #1; tw = rd_tw; rd_en = 1'b0;
        chk("R11 state at offset", tw, 32'h0000_0020);

        // R12: reads are side-effect free, and rd_en low gives zero
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        #1; tw = rd_tw;
        chk("R12 held read", tw, 32'h0000_0020);
        rd_en = 1'b0; #1;
        chk("R12 idle read zero", rd_tw, 32'h0);

        // Scan-chain flavour
        do_reset();
        drive(1'b1, 32'h1, 9'h0);
        drive(1'b0, 32'h0, EV_ORUN);
        rd_en = 1'b1; #1; sc = rd_sc; rd_en = 1'b0;
        chk("R5 scan overrun set", sc, 32'h3);
        drive(1'b1, 32'h3, 9'h0);
        rd_en = 1'b1; #1; sc = rd_sc; rd_en = 1'b0;
        chk("R6 scan w1c overrun", sc, 32'h1);
        drive(1'b0, 32'h0, EV_ERR);
        drive(1'b1, 32'h1, 9'h0);
        rd_en = 1'b1; #1; sc = rd_sc; rd_en = 1'b0;
        chk("R6 scan write zero keeps", sc, 32'h21);
        drive(1'b1, 32'h21, 9'h0);
        rd_en = 1'b1; #1; sc = rd_sc; rd_en = 1'b0;
        chk("R6 scan w1c error", sc, 32'h1);
        drive(1'b0, 32'h0, EV_ERR);
        drive(1'b0, 32'h0, EV_CSTK);
        rd_en = 1'b1; #1; sc = rd_sc; rd_en = 1'b0;
        chk("R7 scan abort clears error", sc, 32'h1);
        drive(1'b1, 32'h21, EV_ERR);
        rd_en = 1'b1; #1; sc = rd_sc; rd_en = 1'b0;
        chk("R10 scan set beats w1c", sc, 32'h21);
        drive(1'b0, 32'h0, EV_ORUN);
        drive(1'b0, 32'h0, EV_CORUN);
        rd_en = 1'b1; #1; sc = rd_sc; rd_en = 1'b0;
        chk("R7 scan abort clears overrun", sc, 32'h21);
        drive(1'b0, 32'h0, EV_RDD | EV_RDOK | EV_WDE);
        rd_en = 1'b1; #1; sc = rd_sc; tw = rd_tw; rd_en = 1'b0;
        chk("R8 R9 scan hides bits 7 and 6", sc, 32'h21);
        chk("R8 R9 two-wire shows bits 7 and 6", tw & 32'hC0, 32'hC0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule